// File: doc/BRIEF.md
# Banked Cartridge Memory Controller

This block sits between a CPU with a 16-bit address bus and a cartridge that carries a large ROM and a small battery-backed RAM. The CPU sees 32 KB of ROM space. The lower 16 KB always shows ROM bank 0. The upper 16 KB shows one switchable bank chosen by software. An 8 KB window at 0xA000 shows either one of four external RAM banks or one register of a separate real-time-clock block.

Writes that land in the ROM address range never reach the ROM. They are decoded as writes to four control slots:

| Slot range | Effect |
|---|---|
| 0x0000–0x1FFF | RAM enable |
| 0x2000–0x3FFF | ROM bank select |
| 0x4000–0x5FFF | RAM-bank or clock-register select |
| 0x6000–0x7FFF | Latch control byte |

Outputs toward the memories and the clock block are registered, so each becomes valid one clock after the request. The read data returned to the CPU is chosen combinationally from the source registered for that request.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A CPU write with address bits [15:13] = 000 enables the RAM window when data bits [3:0] equal 0xA. Any other low nibble disables it.
- R2: A write with address bits [15:13] = 001 loads the ROM bank register with data bits [6:0]. A data byte of exactly 0x00 loads 1 instead, so 0x80 loads bank 0.
- R3: A read below 0x4000 drives `rom_addr` = address[13:0] with all bank bits zero.
- R4: A read in 0x4000–0x7FFF drives `rom_addr` = bank × 0x4000 + address[13:0].
- R5: A write with address bits [15:13] = 010 and data 0x00–0x03 selects that RAM bank and clears clock mode.
- R6: A write with address bits [15:13] = 010 and data 0x08–0x0C sets clock mode, with `rtc_idx` = data − 8.
- R7: Any other data value written to the select slot leaves the RAM bank, the clock mode and `rtc_idx` unchanged.
- R8: When RAM is enabled and clock mode is off, the RAM window 0xA000–0xBFFF behaves as follows:
  - `ram_addr` = bank × 0x2000 + address[12:0].
  - A read asserts `ram_cs` and returns `ram_rdata`.
  - A write asserts `ram_we` with `ram_wdata` equal to the data.
- R9: While RAM is disabled, reads of the RAM window return 0xFF. Writes assert neither `ram_we` nor `rtc_wr`.
- R10: When RAM is enabled and clock mode is on, the RAM window behaves as follows:
  - Reads return `rtc_rdata`, the latched copy of register `rtc_idx` in the clock block.
  - Writes pulse `rtc_wr` with `rtc_wdata` equal to the data, telling the clock block to load both its live and latched copies.
  - `ram_cs` and `ram_we` stay low.
- R11: A write with address bits [15:13] = 011 stores the data byte. `rtc_latch_stb` pulses for one cycle only when the stored byte was 0x00 and the new byte is 0x01.
- R12: After reset the ROM bank is 1, the RAM bank is 0, RAM is disabled, clock mode is off and the stored latch byte is 0x01.
- R13: Reads at 0x8000–0x9FFF and 0xC000–0xFFFF assert no select and return 0xFF. With no read pending, `cpu_rdata` is also 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_rdata | output | 8 | Read data, valid one cycle after the read |
| rom_addr | output | ROM_BANK_W+14 | Translated ROM byte address |
| rom_cs | output | 1 | ROM read select |
| rom_rdata | input | 8 | ROM data for `rom_addr` |
| ram_addr | output | RAM_BANK_W+13 | Translated RAM byte address |
| ram_cs | output | 1 | RAM read select |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM data for `ram_addr` |
| rtc_idx | output | clog2(NUM_RTC_REGS) | Selected clock register |
| rtc_mode | output | 1 | RAM window redirected to the clock block |
| rtc_latch_stb | output | 1 | One-cycle latch command |
| rtc_wr | output | 1 | Clock register write strobe |
| rtc_wdata | output | 8 | Clock register write data |
| rtc_rdata | input | 8 | Latched value of register `rtc_idx` |

## Verification
The bench sweeps all 256 data values through the enable, ROM-bank and select slots.

- A design that tested only bit 3 or the whole byte for the enable key would open the RAM for the wrong values.
- A design that substituted bank 1 after masking, instead of before, would turn 0x80 into bank 1 rather than bank 0.
- Select values between the two accepted ranges are followed by a RAM-window read. A design that decoded them loosely would move the bank or enter clock mode.

Latch sequences cover the other corner cases:

- 0 then 1 must pulse.
- 1 then 1 must not pulse.
- 2 then 1 must not pulse.
- The reset value 1 must not count as a prior 0.

A design that compared the wrong history byte fires on one of these.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int ROM_OFS_W    = 14;
  localparam int RAM_OFS_W    = 13;
  localparam int RTC_SEL_BASE = 8;
  localparam logic [3:0] ENABLE_KEY = 4'hA;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_RAM  = 2'd2,
    SRC_RTC  = 2'd3
  } rd_src_e;

  typedef enum logic [1:0] {
    SLOT_RAMEN   = 2'd0,
    SLOT_ROMBANK = 2'd1,
    SLOT_SELECT  = 2'd2,
    SLOT_LATCH   = 2'd3
  } ctrl_slot_e;
endpackage

// File: rtl/cbc_decode.sv
module cbc_decode import cbc_pkg::*; (
  input  logic [15:0] addr,
  output logic        in_rom,
  output logic        rom_hi,
  output logic        in_ram,
  output ctrl_slot_e  slot
);
  always_comb begin
    in_rom = ~addr[15];
    rom_hi = addr[14];
    in_ram = (addr[15:13] == 3'b101);
    slot   = ctrl_slot_e'(addr[14:13]);
  end
endmodule

// File: rtl/cbc_regs.sv
module cbc_regs import cbc_pkg::*; #(
  parameter int ROM_BANK_W   = 7,
  parameter int RAM_BANK_W   = 2,
  parameter int NUM_RTC_REGS = 5,
  parameter int IDX_W        = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  ctrl_slot_e            slot,
  input  logic [7:0]            wdata,
  output logic                  ram_en,
  output logic [ROM_BANK_W-1:0] rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  rtc_mode,
  output logic [IDX_W-1:0]      rtc_idx,
  output logic                  latch_stb
);
  localparam int         NUM_RAM_BANKS = 1 << RAM_BANK_W;
  localparam logic [7:0] RAM_LIM       = 8'(NUM_RAM_BANKS);
  localparam logic [7:0] RTC_LO        = 8'(RTC_SEL_BASE);
  localparam logic [7:0] RTC_HI        = 8'(RTC_SEL_BASE + NUM_RTC_REGS);

  logic [7:0] latch_q;
  logic       sel_ram, sel_rtc;
  logic [7:0] rtc_off;

  always_comb begin
    sel_ram = (wdata < RAM_LIM);
    sel_rtc = (wdata >= RTC_LO) && (wdata < RTC_HI);
    rtc_off = wdata - RTC_LO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_en    <= 1'b0;
      rom_bank  <= ROM_BANK_W'(1);
      ram_bank  <= '0;
      rtc_mode  <= 1'b0;
      rtc_idx   <= '0;
      latch_q   <= 8'h01;
      latch_stb <= 1'b0;
    end else begin
      latch_stb <= 1'b0;
      if (wr_en) begin
        case (slot)
          SLOT_RAMEN:   ram_en <= (wdata[3:0] == ENABLE_KEY);
          SLOT_ROMBANK: rom_bank <= (wdata == 8'h00) ? ROM_BANK_W'(1)
                                                     : wdata[ROM_BANK_W-1:0];
          SLOT_SELECT: begin
            if (sel_ram) begin
              ram_bank <= wdata[RAM_BANK_W-1:0];
              rtc_mode <= 1'b0;
            end else if (sel_rtc) begin
              rtc_mode <= 1'b1;
              rtc_idx  <= rtc_off[IDX_W-1:0];
            end
          end
          default: begin
            latch_q   <= wdata;
            latch_stb <= (latch_q == 8'h00) && (wdata == 8'h01);
          end
        endcase
      end
    end
  end

  // R11
  latch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    latch_stb |=> !latch_stb);

  // R6
  rtc_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    rtc_mode |-> (rtc_idx < IDX_W'(NUM_RTC_REGS)));

  // R2
  rom_bank_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && slot == SLOT_ROMBANK && wdata == 8'h00) |=> (rom_bank == ROM_BANK_W'(1)));

  // R7
  select_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && slot == SLOT_SELECT && !sel_ram && !sel_rtc)
      |=> ($stable(ram_bank) && $stable(rtc_mode) && $stable(rtc_idx)));
endmodule

// File: rtl/cbc_xlate.sv
module cbc_xlate import cbc_pkg::*; #(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [15:0]                     addr,
  input  logic [7:0]                      wdata,
  input  logic                            rd,
  input  logic                            wr,
  input  logic                            in_rom,
  input  logic                            rom_hi,
  input  logic                            in_ram,
  input  logic                            ram_en,
  input  logic [ROM_BANK_W-1:0]           rom_bank,
  input  logic [RAM_BANK_W-1:0]           ram_bank,
  input  logic                            rtc_mode,
  output logic [ROM_BANK_W+ROM_OFS_W-1:0] rom_addr,
  output logic                            rom_cs,
  output logic [RAM_BANK_W+RAM_OFS_W-1:0] ram_addr,
  output logic                            ram_cs,
  output logic                            ram_we,
  output logic [7:0]                      ram_wdata,
  output logic                            rtc_wr,
  output logic [7:0]                      rtc_wdata,
  output rd_src_e                         src
);
  logic win_open;

  always_comb win_open = in_ram && ram_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr  <= '0;
      rom_cs    <= 1'b0;
      ram_addr  <= '0;
      ram_cs    <= 1'b0;
      ram_we    <= 1'b0;
      ram_wdata <= '0;
      rtc_wr    <= 1'b0;
      rtc_wdata <= '0;
      src       <= SRC_NONE;
    end else begin
      rom_cs    <= rd && in_rom;
      rom_addr  <= rom_hi ? {rom_bank, addr[ROM_OFS_W-1:0]}
                          : {{ROM_BANK_W{1'b0}}, addr[ROM_OFS_W-1:0]};
      ram_addr  <= {ram_bank, addr[RAM_OFS_W-1:0]};
      ram_cs    <= rd && win_open && !rtc_mode;
      ram_we    <= wr && win_open && !rtc_mode;
      rtc_wr    <= wr && win_open && rtc_mode;
      ram_wdata <= wdata;
      rtc_wdata <= wdata;
      if (rd && in_rom)        src <= SRC_ROM;
      else if (rd && win_open) src <= rtc_mode ? SRC_RTC : SRC_RAM;
      else                     src <= SRC_NONE;
    end
  end

  // R9
  we_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_we || rtc_wr) |-> $past(ram_en));

  // R10
  select_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_cs, ram_cs, ram_we, rtc_wr}));

  // R3
  rom_low_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && in_rom && !rom_hi) |=> (rom_addr[ROM_BANK_W+ROM_OFS_W-1:ROM_OFS_W] == '0));

  // R13
  outside_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && !in_rom && !in_ram) |=> (!rom_cs && !ram_cs && src == SRC_NONE));
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl import cbc_pkg::*; #(
  parameter int ROM_BANK_W   = 7,
  parameter int RAM_BANK_W   = 2,
  parameter int NUM_RTC_REGS = 5
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [15:0]                         cpu_addr,
  input  logic [7:0]                          cpu_wdata,
  input  logic                                cpu_rd,
  input  logic                                cpu_wr,
  output logic [7:0]                          cpu_rdata,
  output logic [ROM_BANK_W+ROM_OFS_W-1:0]     rom_addr,
  output logic                                rom_cs,
  input  logic [7:0]                          rom_rdata,
  output logic [RAM_BANK_W+RAM_OFS_W-1:0]     ram_addr,
  output logic                                ram_cs,
  output logic                                ram_we,
  output logic [7:0]                          ram_wdata,
  input  logic [7:0]                          ram_rdata,
  output logic [$clog2(NUM_RTC_REGS)-1:0]     rtc_idx,
  output logic                                rtc_mode,
  output logic                                rtc_latch_stb,
  output logic                                rtc_wr,
  output logic [7:0]                          rtc_wdata,
  input  logic [7:0]                          rtc_rdata
);
  localparam int IDX_W = $clog2(NUM_RTC_REGS);

  logic                  in_rom, rom_hi, in_ram;
  ctrl_slot_e            slot;
  logic                  ram_en;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [RAM_BANK_W-1:0] ram_bank;
  rd_src_e               src;

  cbc_decode u_dec (
    .addr   (cpu_addr),
    .in_rom (in_rom),
    .rom_hi (rom_hi),
    .in_ram (in_ram),
    .slot   (slot)
  );

  cbc_regs #(
    .ROM_BANK_W   (ROM_BANK_W),
    .RAM_BANK_W   (RAM_BANK_W),
    .NUM_RTC_REGS (NUM_RTC_REGS),
    .IDX_W        (IDX_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cpu_wr && in_rom),
    .slot      (slot),
    .wdata     (cpu_wdata),
    .ram_en    (ram_en),
    .rom_bank  (rom_bank),
    .ram_bank  (ram_bank),
    .rtc_mode  (rtc_mode),
    .rtc_idx   (rtc_idx),
    .latch_stb (rtc_latch_stb)
  );

  cbc_xlate #(
    .ROM_BANK_W (ROM_BANK_W),
    .RAM_BANK_W (RAM_BANK_W)
  ) u_xlate (
    .clk       (clk),
    .rst       (rst),
    .addr      (cpu_addr),
    .wdata     (cpu_wdata),
    .rd        (cpu_rd),
    .wr        (cpu_wr),
    .in_rom    (in_rom),
    .rom_hi    (rom_hi),
    .in_ram    (in_ram),
    .ram_en    (ram_en),
    .rom_bank  (rom_bank),
    .ram_bank  (ram_bank),
    .rtc_mode  (rtc_mode),
    .rom_addr  (rom_addr),
    .rom_cs    (rom_cs),
    .ram_addr  (ram_addr),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .ram_wdata (ram_wdata),
    .rtc_wr    (rtc_wr),
    .rtc_wdata (rtc_wdata),
    .src       (src)
  );

  always_comb begin
    case (src)
      SRC_ROM: cpu_rdata = rom_rdata;
      SRC_RAM: cpu_rdata = ram_rdata;
      SRC_RTC: cpu_rdata = rtc_rdata;
      default: cpu_rdata = 8'hFF;
    endcase
  end

  // R13
  idle_open_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (!cpu_rd) |=> (cpu_rdata == 8'hFF));
endmodule

// File: tb/cart_bank_ctrl_tb_top.sv
module cart_bank_ctrl_tb_top;
  localparam int RBW = 7;
  localparam int ABW = 2;
  localparam int NRT = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [RBW+13:0] rom_addr;
  logic        rom_cs;
  logic [7:0]  rom_rdata;
  logic [ABW+12:0] ram_addr;
  logic        ram_cs, ram_we;
  logic [7:0]  ram_wdata, ram_rdata;
  logic [2:0]  rtc_idx;
  logic        rtc_mode, rtc_latch_stb, rtc_wr;
  logic [7:0]  rtc_wdata, rtc_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] rom_model(input logic [RBW+13:0] a);
    return a[7:0] ^ {1'b0, a[RBW+13:14]};
  endfunction
  function automatic logic [7:0] ram_model(input logic [ABW+12:0] a);
    return a[7:0] ^ {a[ABW+12:13], 6'h15};
  endfunction

  assign rom_rdata = rom_model(rom_addr);
  assign ram_rdata = ram_model(ram_addr);
  assign rtc_rdata = 8'hC0 + {5'd0, rtc_idx};

  cart_bank_ctrl #(.ROM_BANK_W(RBW), .RAM_BANK_W(ABW), .NUM_RTC_REGS(NRT)) dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .rom_addr(rom_addr), .rom_cs(rom_cs), .rom_rdata(rom_rdata),
    .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .rtc_idx(rtc_idx), .rtc_mode(rtc_mode), .rtc_latch_stb(rtc_latch_stb),
    .rtc_wr(rtc_wr), .rtc_wdata(rtc_wdata), .rtc_rdata(rtc_rdata));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic op(input logic rd, input logic wr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_rd = rd; cpu_wr = wr;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic wr_op(input logic [15:0] a, input logic [7:0] d);
    op(1'b0, 1'b1, a, d);
  endtask
  task automatic rd_op(input logic [15:0] a);
    op(1'b1, 1'b0, a, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  bank_m;
    logic [1:0]  rbank_m;
    logic        mode_m;
    logic [2:0]  idx_m;
    logic [13:0] ofs;
    logic [12:0] rofs;
    logic [RBW+13:0] ea;
    logic [ABW+12:0] ra;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    chk("R12 rom_cs", rom_cs, 0);
    chk("R12 rtc_mode", rtc_mode, 0);
    chk("R12 latch idle", rtc_latch_stb, 0);
    chk("R13 idle rdata", cpu_rdata, 8'hFF);
    rd_op(16'h4000);
    chk("R12 rom bank 1", rom_addr, 21'h04000);
    rd_op(16'hA010);
    chk("R12 ram disabled", cpu_rdata, 8'hFF);
    chk("R12 ram_cs", ram_cs, 0);
    wr_op(16'h6000, 8'h01);
    chk("R12 latch byte 1", rtc_latch_stb, 0);

    // R2 / R4 sweep over all ROM bank values
    for (int d = 0; d < 256; d++) begin
      wr_op(16'h2000 | 16'((d * 37) & 16'h1FFF), 8'(d));
      bank_m = (d == 0) ? 8'd1 : 8'(d & 8'h7F);
      ofs = 14'((d * 97) & 16'h3FFF);
      rd_op(16'h4000 | {2'b00, ofs});
      ea = {bank_m[RBW-1:0], ofs};
      chk("R2 R4 rom_addr", rom_addr, ea);
      chk("R4 rom rdata", cpu_rdata, rom_model(ea));
      chk("R4 rom_cs", rom_cs, 1);
    end

    // R3 lower window ignores the bank
    wr_op(16'h2000, 8'h55);
    for (int k = 0; k < 8; k++) begin
      ofs = 14'((k * 2047 + 3) & 16'h3FFF);
      rd_op({2'b00, ofs});
      chk("R3 rom0 addr", rom_addr, {7'd0, ofs});
      chk("R3 rom0 data", cpu_rdata, rom_model({7'd0, ofs}));
    end

    // R1 sweep over enable values
    for (int d = 0; d < 256; d++) begin
      wr_op(16'((d * 53) & 16'h1FFF), 8'(d));
      rd_op(16'hA123);
      if ((d & 8'h0F) == 8'h0A) begin
        chk("R1 enabled cs", ram_cs, 1);
        chk("R1 enabled data", cpu_rdata, ram_model(15'h0123));
      end else begin
        chk("R1 disabled cs", ram_cs, 0);
        chk("R1 disabled data", cpu_rdata, 8'hFF);
      end
    end

    // R5 R6 R7 sweep over select values
    wr_op(16'h0000, 8'h0A);
    rbank_m = 2'd0; mode_m = 1'b0; idx_m = 3'd0;
    for (int d = 0; d < 256; d++) begin
      wr_op(16'h4000 | 16'((d * 29) & 16'h1FFF), 8'(d));
      if (d < 4) begin
        rbank_m = 2'(d); mode_m = 1'b0;
      end else if (d >= 8 && d <= 12) begin
        mode_m = 1'b1; idx_m = 3'(d - 8);
      end
      rofs = 13'((d * 71) & 16'h1FFF);
      rd_op(16'hA000 | {3'b000, rofs});
      chk("R5 R6 R7 mode", rtc_mode, mode_m);
      if (mode_m) begin
        chk("R6 R7 idx", rtc_idx, idx_m);
        chk("R10 rtc data", cpu_rdata, 8'hC0 + {5'd0, idx_m});
        chk("R10 no ram_cs", ram_cs, 0);
      end else begin
        ra = {rbank_m, rofs};
        chk("R5 R7 R8 ram_addr", ram_addr, ra);
        chk("R8 ram data", cpu_rdata, ram_model(ra));
      end
    end

    // R8 writes per bank
    for (int b = 0; b < 4; b++) begin
      wr_op(16'h4000, 8'(b));
      wr_op(16'hBFFE - 16'(b), 8'(8'h30 + b));
      chk("R8 ram_we", ram_we, 1);
      chk("R8 wr addr", ram_addr, {2'(b), 13'(13'h1FFE - b)});
      chk("R8 wr data", ram_wdata, 8'(8'h30 + b));
      chk("R8 no rtc_wr", rtc_wr, 0);
    end

    // R10 clock register writes
    wr_op(16'h4000, 8'h0A);
    wr_op(16'hB000, 8'h5A);
    chk("R10 rtc_wr", rtc_wr, 1);
    chk("R10 rtc_wdata", rtc_wdata, 8'h5A);
    chk("R10 rtc_idx", rtc_idx, 2);
    chk("R10 no ram_we", ram_we, 0);

    // R9 disabled window
    wr_op(16'h0000, 8'h00);
    wr_op(16'hA004, 8'h77);
    chk("R9 no rtc_wr", rtc_wr, 0);
    chk("R9 no ram_we", ram_we, 0);
    wr_op(16'h4000, 8'h01);
    wr_op(16'hA004, 8'h77);
    chk("R9 no ram_we bank", ram_we, 0);
    rd_op(16'hA004);
    chk("R9 read FF", cpu_rdata, 8'hFF);

    // R11 latch sequences
    wr_op(16'h6000, 8'h00);
    chk("R11 zero no pulse", rtc_latch_stb, 0);
    wr_op(16'h7FFF, 8'h01);
    chk("R11 pulse", rtc_latch_stb, 1);
    @(negedge clk);
    chk("R11 pulse one cycle", rtc_latch_stb, 0);
    wr_op(16'h6000, 8'h01);
    chk("R11 1 then 1", rtc_latch_stb, 0);
    wr_op(16'h6000, 8'h02);
    wr_op(16'h6000, 8'h01);
    chk("R11 2 then 1", rtc_latch_stb, 0);

    // R13 outside windows
    wr_op(16'h0000, 8'h0A);
    rd_op(16'h8000);
    chk("R13 8000 data", cpu_rdata, 8'hFF);
    chk("R13 8000 cs", {rom_cs, ram_cs}, 0);
    rd_op(16'hC000);
    chk("R13 C000 data", cpu_rdata, 8'hFF);
    rd_op(16'hFFFF);
    chk("R13 FFFF cs", {rom_cs, ram_cs}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule